// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a 32-pin general purpose I/O controller behind a simple memory-mapped register bus. Software sets, for each pin, an input enable, an output enable, an output value, an output inversion and a pull-up. Any enabled input can latch four kinds of interrupt condition: rising edge, falling edge, high level and low level. Each kind has its own pending word and enable word. Each pin drives its own interrupt line, which a system interrupt controller takes in.

Every pin first settles on a single raw value. An output-enabled pin takes its driven pad value. A pin with an external driver takes the pad input. An undriven pin takes its pull-up setting. That raw value passes through a two-flop synchroniser and is then masked by the input enable. Because an output-enabled pin loops its own driven value back, software can enable both directions on a pin and trigger its interrupts by writing the output register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_out` and `irq` are 0, and reads of unmapped offsets (0x14, 0x38, 0x3C) return 0. Register offsets: 0x00 input (read-only), 0x04 input enable, 0x08 output enable, 0x0C output value, 0x10 pull-up, 0x40 output invert. For each interrupt kind k (0 rise, 1 fall, 2 high, 3 low), the enable word sits at 0x18+8k and the pending word at 0x1C+8k.
- R2: `irq[i]` is high exactly when, for some kind, both the pending bit i and the enable bit i of that kind are 1.
- R3: Each of the four kinds has its own 32-bit enable word and its own 32-bit pending word. Enable words read back the value written to them.
- R4: `pad_out` equals the output value XOR the output invert word, and `pad_oe` equals the output enable word. Neither changes without a register write.
- R5: The raw value of pin i is `pad_out[i]` when output enable bit i is 1. Otherwise it is `pad_in[i]` when `pad_drv[i]` is 1, and otherwise it is pull-up bit i. Offset 0x00 reads the raw value after two clock stages of synchronisation, ANDed with the input enable.
- R6: A write to a pending word clears each bit where the write data has a 1 and leaves bits written 0 unchanged. A bit whose condition holds in the same cycle stays set.
- R7: Pending bits latch whether or not the matching enable bit is set. Enable bits only gate `irq`.
- R8: A rising (falling) edge is a 0-to-1 (1-to-0) change of the synchronised input between consecutive clocks. After a register write at clock edge E0 changes a looped-back pin, its pending bit and `irq` change after edge E3 and not before.
- R9: The high (low) pending bit is set on every clock while the synchronised input is 1 (0). Clearing it while the level persists leaves it set.
- R10: A pin whose input enable is 0 reads 0 at 0x00 and sets no pending bit, whatever its pad does.
- R11: A pin with both output and input enabled sets interrupt pending bits from writes to the output value register alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | 32 | Pad input values |
| pad_drv | input | 32 | 1 where an external driver is present on the pad |
| pad_out | output | 32 | Driven pad values after inversion |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 32 | One interrupt line per pin |

## Verification
The assertions assume that `reg_addr`, `reg_wr` and `reg_wdata` are stable around each rising clock edge, and that pads change state only between edges. The bench drives every input on the falling edge, so both assumptions hold. The stickiness checks on the pending words also assume that only an addressed write can lower a pending bit. For that reason the bench never lowers a pending bit by any other means and never pulses reset partway through a run.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  input  logic [N-1:0]  pad_in,
  input  logic [N-1:0]  pad_drv,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  output logic [N-1:0]  irq
);
  localparam int KINDS = 4;
  localparam logic [AW-1:0] A_IN   = AW'(8'h00);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h04);
  localparam logic [AW-1:0] A_OEN  = AW'(8'h08);
  localparam logic [AW-1:0] A_OVAL = AW'(8'h0C);
  localparam logic [AW-1:0] A_PULL = AW'(8'h10);
  localparam logic [AW-1:0] A_INV  = AW'(8'h40);

  logic [N-1:0] in_en, out_en, out_val, pull_en, out_inv;
  logic [N-1:0] sync1, sync2, prev;
  logic [N-1:0] ie  [KINDS];
  logic [N-1:0] ip  [KINDS];
  logic [N-1:0] set [KINDS];
  logic [N-1:0] clr [KINDS];
  logic [N-1:0] raw, in_val, pend_any;

  assign pad_out = out_val ^ out_inv;
  assign pad_oe  = out_en;
  assign raw     = (out_en & pad_out) | (~out_en & ((pad_drv & pad_in) | (~pad_drv & pull_en)));
  assign in_val  = sync2 & in_en;

  assign set[0] = in_val & ~prev;
  assign set[1] = ~in_val & prev & in_en;
  assign set[2] = in_val;
  assign set[3] = ~in_val & in_en;

  always_comb begin
    irq = '0;
    pend_any = '0;
    for (int k = 0; k < KINDS; k++) begin
      clr[k] = (reg_wr && reg_addr == AW'(28 + 8 * k)) ? reg_wdata : '0;
      irq = irq | (ip[k] & ie[k]);
      pend_any = pend_any | ip[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en <= '0; out_en <= '0; out_val <= '0; pull_en <= '0; out_inv <= '0;
      sync1 <= '0; sync2 <= '0; prev <= '0;
      for (int k = 0; k < KINDS; k++) begin
        ie[k] <= '0;
        ip[k] <= '0;
      end
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      prev  <= in_val;
      if (reg_wr) begin
        case (reg_addr)
          A_IEN:   in_en   <= reg_wdata;
          A_OEN:   out_en  <= reg_wdata;
          A_OVAL:  out_val <= reg_wdata;
          A_PULL:  pull_en <= reg_wdata;
          A_INV:   out_inv <= reg_wdata;
          default: ;
        endcase
      end
      for (int k = 0; k < KINDS; k++) begin
        if (reg_wr && reg_addr == AW'(24 + 8 * k)) ie[k] <= reg_wdata;
        ip[k] <= (ip[k] & ~clr[k]) | set[k];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_IN:    reg_rdata = in_val;
      A_IEN:   reg_rdata = in_en;
      A_OEN:   reg_rdata = out_en;
      A_OVAL:  reg_rdata = out_val;
      A_PULL:  reg_rdata = pull_en;
      A_INV:   reg_rdata = out_inv;
      default: ;
    endcase
    for (int k = 0; k < KINDS; k++) begin
      if (reg_addr == AW'(24 + 8 * k)) reg_rdata = ie[k];
      if (reg_addr == AW'(28 + 8 * k)) reg_rdata = ip[k];
    end
  end

  assert_reset_clean_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (pend_any == '0 && pad_out == '0 && irq == '0));

  assert_irq_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_any == '0) |-> (irq == '0));

  assert_pad_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(pad_out) && $stable(pad_oe));

  for (genvar k = 0; k < KINDS; k++) begin : g_chk
    assert_ip_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == AW'(28 + 8 * k)) |=> ((ip[k] & $past(ip[k])) == $past(ip[k])));

    assert_ip_needs_ien_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ip[k] & ~$past(ip[k]) & ~$past(in_en)) == '0));
  end
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_drv = '0;
  logic [31:0] pad_out, pad_oe, irq;
  int errors = 0;
  int checks = 0;
  logic [31:0] r;

  always #5 clk = ~clk;

  gpio_irq_ctrl u0 (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
                    .pad_in, .pad_drv, .pad_out, .pad_oe, .irq);

  // fields: ien, oen, oval, inv, pull, drv, pin, exp_in, exp_pad_out
  localparam logic [31:0] VEC [6][9] = '{
    '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'h0},
    '{32'hFFFF0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hA5A5A5A5, 32'hA5A50000, 32'h0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12345678, 32'h0, 32'h0, 32'h0, 32'h0, 32'h12345678, 32'h12345678},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12345678, 32'hFFFF0000, 32'h0, 32'h0, 32'h0, 32'hEDCB5678, 32'hEDCB5678},
    '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0F0F0F0F, 32'h00FF00FF, 32'h0, 32'h0F000F00, 32'h0},
    '{32'h0000FFFF, 32'h0000FF00, 32'h0000F0F0, 32'h00000F0F, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0000FFFF, 32'h0000FFFF}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    cyc(2);
    rst_n = 1;
    cyc(2);
    // R1 reset state
    for (int a = 0; a <= 8'h40; a += 4) begin
      rd(a[7:0], r);
      chk("R1 reset read", r, 32'h0);
    end
    chk("R1 reset pad_out", pad_out, 32'h0);
    chk("R1 reset irq", irq, 32'h0);

    // R3 enable words read back
    for (int k = 0; k < 4; k++) begin
      wr(8'(24 + 8 * k), 32'h5A000000 | k);
      rd(8'(24 + 8 * k), r);
      chk("R3 enable readback", r, 32'h5A000000 | k);
      wr(8'(24 + 8 * k), 32'h0);
    end

    // R4 R5 table of pin configurations
    for (int v = 0; v < 6; v++) begin
      wr(8'h04, VEC[v][0]); wr(8'h08, VEC[v][1]); wr(8'h0C, VEC[v][2]);
      wr(8'h40, VEC[v][3]); wr(8'h10, VEC[v][4]);
      pad_drv = VEC[v][5]; pad_in = VEC[v][6];
      cyc(3);
      rd(8'h00, r);
      chk("R5 input value", r, VEC[v][7]);
      chk("R4 pad_out", pad_out, VEC[v][8]);
      chk("R4 pad_oe", pad_oe, VEC[v][1]);
    end

    // quiet all, then loop back pin 3
    pad_drv = '0; pad_in = '0;
    wr(8'h04, 0); wr(8'h08, 0); wr(8'h0C, 0); wr(8'h40, 0); wr(8'h10, 0);
    cyc(4);
    for (int k = 0; k < 4; k++) wr(8'(28 + 8 * k), 32'hFFFFFFFF);
    rd(8'h1C, r); chk("R6 clear all pending", r, 32'h0);
    wr(8'h04, 32'h8); wr(8'h08, 32'h8);
    cyc(4);
    wr(8'h18, 32'h8);
    chk("R2 irq idle", irq, 32'h0);
    wr(8'h0C, 32'h8);
    cyc(2);
    chk("R8 no early rise irq", irq, 32'h0);
    cyc(1);
    chk("R8 R11 rise irq after E3", irq, 32'h8);
    rd(8'h1C, r); chk("R11 rise pending", r, 32'h8);

    // R7 fall pending latches without enable
    wr(8'h0C, 32'h0);
    cyc(4);
    rd(8'h24, r); chk("R7 fall pending without enable", r, 32'h8);
    wr(8'h1C, 32'h8);
    chk("R2 irq drops after rise clear", irq, 32'h0);
    wr(8'h24, 32'h0);
    rd(8'h24, r); chk("R6 write zero keeps pending", r, 32'h8);
    wr(8'h20, 32'h8);
    chk("R2 fall irq when enabled", irq, 32'h8);
    wr(8'h24, 32'h8);
    chk("R6 clear fall drops irq", irq, 32'h0);
    wr(8'h18, 0); wr(8'h20, 0);

    // R9 level pending
    wr(8'h28, 32'h8);
    wr(8'h0C, 32'h8);
    cyc(4);
    chk("R9 high irq", irq, 32'h8);
    wr(8'h2C, 32'h8);
    rd(8'h2C, r); chk("R9 high stays while high", r, 32'h8);
    wr(8'h0C, 32'h0);
    cyc(4);
    wr(8'h2C, 32'h8);
    rd(8'h2C, r); chk("R9 high cleared once low", r, 32'h0);
    chk("R2 irq off after high clear", irq, 32'h0);
    wr(8'h30, 32'h8);
    chk("R9 low irq", irq, 32'h8);
    wr(8'h30, 0);

    // R10 disabled pin 5 with external toggles
    for (int k = 0; k < 4; k++) wr(8'(28 + 8 * k), 32'hFFFFFFFF);
    pad_drv = 32'h20;
    for (int t = 0; t < 4; t++) begin
      pad_in = (t % 2 == 0) ? 32'h20 : 32'h0;
      cyc(3);
      rd(8'h00, r); chk("R10 disabled input reads 0", r & 32'h20, 32'h0);
    end
    for (int k = 0; k < 4; k++) begin
      rd(8'(28 + 8 * k), r);
      chk("R10 no pending on disabled pin", r & 32'h20, 32'h0);
    end
    rd(8'h38, r); chk("R1 unmapped read", r, 32'h0);

    summary();
    $finish;
  end
endmodule